// File: doc/BRIEF.md
# Overpower Protection Timeout Controller

This block supplies the digital control around a cycle-by-cycle overpower limit in a switching power converter. The converter's controller presents a drive request for each conduction stroke. An analog comparator reports when the sensed current has passed the overpower reference. When that flag appears during a stroke, the block blanks the gate drive for the remainder of the stroke, so the primary stroke ends early.

While overpower keeps recurring from one switching cycle to the next, a timer advances on a fixed timebase tick. When the timer reaches its limit, a protection request is latched and switching is held off until reset. The limit is short while the converter is still starting up. It becomes long once the output has been reported in regulation. Overpower seen together with undervoltage lockout enters protection at once, whatever the timer holds. The analog comparison and the reference generation sit outside this block.

Top module: `opp_timeout_ctrl`

## Requirements
- R1: After a synchronous reset, prot_o is 0. With prot_o low and no overpower, gate_o equals drv_req_i in the same cycle. A switching cycle is one high phase of drv_req_i followed by at least one low cycle.
- R2: If ocp_i is high while drv_req_i is high, gate_o is 0 in that same cycle and stays 0 until drv_req_i goes low. The next high phase of drv_req_i drives gate_o again.
- R3: The timer starts at the clock edge that follows an overpower event (drv_req_i and ocp_i both high). From then on it advances by one on each tick_i. It is cleared when a high phase of drv_req_i ends without any overpower event in it.
- R4: Before regulation has been seen, prot_o rises at the edge that ends the cycle holding the LIM_START-th counted tick (default 384, which is 38.4 ms at a 0.1 ms tick).
- R5: Once reg_ok_i has been high for at least one cycle, the limit becomes LIM_REG (default 1920). It stays there until reset, and the start-up limit applies again after reset.
- R6: Once set, prot_o stays 1 until reset. While prot_o is 1, gate_o is 0 whatever drv_req_i is.
- R7: If uvlo_i is high while overpower is present, prot_o is 1 from the next edge, whatever the count. Overpower is present when the timer is running or when an overpower event occurs in that cycle.
- R8: uvlo_i high without any overpower present has no effect: prot_o stays 0 and gate_o follows drv_req_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drv_req_i | input | 1 | Drive request from the switching controller; high during a conduction stroke |
| ocp_i | input | 1 | Comparator flag: sensed current above the overpower reference |
| reg_ok_i | input | 1 | Output voltage has reached regulation |
| uvlo_i | input | 1 | Undervoltage lockout detected |
| tick_i | input | 1 | Single-cycle timebase pulse, nominally every 0.1 ms |
| gate_o | output | 1 | Gated driver output |
| prot_o | output | 1 | Latched overpower protection mode |

## Verification
In one clock cycle the timer expiry and the undervoltage path can both request protection. In the same cycle, blanking of the gate can also coincide with a new overpower event. The bench drives uvlo_i while the timer is running, both within an active overpower stroke and between strokes. It also lets ticks land on the very cycles where events start or strokes end cleanly. A behavioural reference model judges each cycle, computing the latch state and the gate level from the requirements and comparing both outputs on every clock.

// File: rtl/opp_pkg.sv
package opp_pkg;

    localparam int unsigned OPP_CNT_W = 16;

    typedef logic [OPP_CNT_W-1:0] opp_count_t;

    typedef enum logic {
        LIM_STARTUP   = 1'b0,
        LIM_REGULATED = 1'b1
    } limit_sel_e;

    typedef struct packed {
        logic       running;
        opp_count_t count;
    } timer_state_t;

    function automatic opp_count_t pick_limit(input limit_sel_e sel,
                                              input opp_count_t startup_lim,
                                              input opp_count_t regulated_lim);
        return (sel == LIM_REGULATED) ? regulated_lim : startup_lim;
    endfunction

endpackage

// File: rtl/opp_stroke_gate.sv
module opp_stroke_gate (
    input  logic clk,
    input  logic rst,
    input  logic drv_req_i,
    input  logic ocp_i,
    input  logic prot_i,
    output logic gate_o,
    output logic op_event_o,
    output logic clean_end_o
);
    logic blank_q;
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            req_q   <= drv_req_i;
            blank_q <= drv_req_i & (blank_q | ocp_i);
        end
    end

    assign op_event_o  = drv_req_i & ocp_i;
    assign clean_end_o = req_q & ~drv_req_i & ~blank_q;
    assign gate_o      = drv_req_i & ~ocp_i & ~blank_q & ~prot_i;

endmodule

// File: rtl/opp_timer.sv
module opp_timer
    import opp_pkg::*;
#(
    parameter int unsigned LIM_START = 384,
    parameter int unsigned LIM_REG   = 1920
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic reg_ok_i,
    input  logic op_event_i,
    input  logic clean_end_i,
    output logic running_o,
    output logic expire_o
);
    localparam opp_count_t START_LIM = opp_count_t'(LIM_START);
    localparam opp_count_t REG_LIM   = opp_count_t'(LIM_REG);

    timer_state_t state_q, state_d;
    limit_sel_e   mode_q;
    opp_count_t   limit;

    assign limit     = pick_limit(mode_q, START_LIM, REG_LIM);
    assign running_o = state_q.running;
    assign expire_o  = state_q.running & tick_i & (state_q.count >= limit - 1'b1);

    always_comb begin
        state_d = state_q;
        if (state_q.running && tick_i && (state_q.count != '1))
            state_d.count = state_q.count + 1'b1;
        if (op_event_i) begin
            state_d.running = 1'b1;
        end else if (clean_end_i) begin
            state_d.running = 1'b0;
            state_d.count   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            mode_q  <= LIM_STARTUP;
        end else begin
            state_q <= state_d;
            if (reg_ok_i)
                mode_q <= LIM_REGULATED;
        end
    end

endmodule

// File: rtl/opp_prot_latch.sv
module opp_prot_latch (
    input  logic clk,
    input  logic rst,
    input  logic expire_i,
    input  logic uvlo_i,
    input  logic running_i,
    input  logic op_event_i,
    output logic prot_o
);
    logic prot_q;
    logic uvlo_trip;

    assign uvlo_trip = uvlo_i & (running_i | op_event_i);

    always_ff @(posedge clk) begin
        if (rst)
            prot_q <= 1'b0;
        else
            prot_q <= prot_q | expire_i | uvlo_trip;
    end

    assign prot_o = prot_q;

endmodule

// File: rtl/opp_timeout_ctrl.sv
module opp_timeout_ctrl #(
    parameter int unsigned LIM_START = 384,
    parameter int unsigned LIM_REG   = 1920
) (
    input  logic clk,
    input  logic rst,
    input  logic drv_req_i,
    input  logic ocp_i,
    input  logic reg_ok_i,
    input  logic uvlo_i,
    input  logic tick_i,
    output logic gate_o,
    output logic prot_o
);
    logic op_event;
    logic clean_end;
    logic running;
    logic expire;

    opp_stroke_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .drv_req_i  (drv_req_i),
        .ocp_i      (ocp_i),
        .prot_i     (prot_o),
        .gate_o     (gate_o),
        .op_event_o (op_event),
        .clean_end_o(clean_end)
    );

    opp_timer #(
        .LIM_START(LIM_START),
        .LIM_REG  (LIM_REG)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .reg_ok_i   (reg_ok_i),
        .op_event_i (op_event),
        .clean_end_i(clean_end),
        .running_o  (running),
        .expire_o   (expire)
    );

    opp_prot_latch u_prot (
        .clk       (clk),
        .rst       (rst),
        .expire_i  (expire),
        .uvlo_i    (uvlo_i),
        .running_i (running),
        .op_event_i(op_event),
        .prot_o    (prot_o)
    );

endmodule

// File: rtl/opp_timeout_checker.sv
module opp_timeout_checker (
    input logic clk,
    input logic rst,
    input logic drv_req_i,
    input logic ocp_i,
    input logic uvlo_i,
    input logic tick_i,
    input logic gate_o,
    input logic prot_o
);
    a_r1_gate_needs_req: assert property (@(posedge clk) disable iff (rst)
        gate_o |-> drv_req_i);

    a_r2_ocp_blanks_now: assert property (@(posedge clk) disable iff (rst)
        ocp_i |-> !gate_o);

    a_r2_blank_holds: assert property (@(posedge clk) disable iff (rst)
        (drv_req_i && ocp_i) |=> (!drv_req_i || !gate_o));

    a_r4_prot_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_o) |-> ($past(uvlo_i) || $past(tick_i)));

    a_r6_prot_sticky: assert property (@(posedge clk) disable iff (rst)
        prot_o |=> prot_o);

    a_r6_gate_off_in_prot: assert property (@(posedge clk) disable iff (rst)
        prot_o |-> !gate_o);

    a_r7_uvlo_trip: assert property (@(posedge clk) disable iff (rst)
        (uvlo_i && drv_req_i && ocp_i) |=> prot_o);
endmodule

bind opp_timeout_ctrl opp_timeout_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .drv_req_i(drv_req_i),
    .ocp_i    (ocp_i),
    .uvlo_i   (uvlo_i),
    .tick_i   (tick_i),
    .gate_o   (gate_o),
    .prot_o   (prot_o)
);

// File: tb/tb_opp_timeout_ctrl.sv
`timescale 1ns/1ps
module tb_opp_timeout_ctrl;
    localparam int LS = 384;
    localparam int LR = 1920;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drv_req = 1'b0, ocp = 1'b0, reg_ok = 1'b0, uvlo = 1'b0, tick = 1'b0;
    logic gate, prot;
    logic tick_en = 1'b0;

    int checks = 0;
    int errors = 0;
    int ticks_seen = 0;
    bit done = 0;

    // reference model state
    bit m_prot, m_blank, m_prev, m_run, m_reg;
    int m_cnt;

    always #5 clk = ~clk;

    opp_timeout_ctrl #(.LIM_START(LS), .LIM_REG(LR)) dut (
        .clk(clk), .rst(rst), .drv_req_i(drv_req), .ocp_i(ocp),
        .reg_ok_i(reg_ok), .uvlo_i(uvlo), .tick_i(tick),
        .gate_o(gate), .prot_o(prot)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // tick generator: one pulse every 5 clocks
    initial begin
        int n = 0;
        forever begin
            @(posedge clk); #1;
            n++;
            tick = tick_en && (n % 5 == 0);
        end
    end

    // reference model, compared on every clock
    always @(negedge clk) begin
        bit exp_gate, lim_hit, ev, cend;
        int lim;
        if (tick) ticks_seen++;
        exp_gate = drv_req && !ocp && !m_blank && !m_prot;
        if (!rst) begin
            check("R1 gate vs model", gate, exp_gate);
            check("R6 prot vs model", prot, m_prot);
        end
        if (rst) begin
            m_prot = 0; m_blank = 0; m_prev = 0; m_run = 0; m_reg = 0; m_cnt = 0;
        end else begin
            lim = m_reg ? LR : LS;
            ev = drv_req && ocp;
            cend = m_prev && !drv_req && !m_blank;
            lim_hit = m_run && tick && (m_cnt >= lim - 1);
            if (lim_hit || (uvlo && (m_run || ev))) m_prot = 1;
            if (m_run && tick) m_cnt++;
            if (ev) m_run = 1;
            else if (cend) begin m_run = 0; m_cnt = 0; end
            m_blank = drv_req && (m_blank || ocp);
            m_prev = drv_req;
            if (reg_ok) m_reg = 1;
        end
    end

    task automatic step(input bit d, input bit o);
        @(posedge clk); #1;
        drv_req = d; ocp = o;
    endtask

    // one switching cycle: 6 high, 4 low; ocp pulse at position pos (-1 = none)
    task automatic stroke(input int pos);
        for (int i = 0; i < 10; i++) step(i < 6, i == pos);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1; drv_req = 0; ocp = 0; reg_ok = 0; uvlo = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 0;
        ticks_seen = 0;
    endtask

    task automatic ocp_until(input int n);
        while (ticks_seen < n) stroke(2);
    endtask

    initial begin
        tick_en = 1;
        do_reset();
        @(negedge clk);
        check("R1 reset prot", prot, 1'b0);
        check("R1 reset gate", gate, 1'b0);

        // R1 plain strokes
        step(1, 0); @(negedge clk); check("R1 gate follows req", gate, 1'b1);
        step(0, 0); @(negedge clk); check("R1 gate low with req low", gate, 1'b0);
        stroke(-1); stroke(-1);

        // R2 blanking inside a stroke
        step(1, 0); @(negedge clk); check("R2 gate before ocp", gate, 1'b1);
        step(1, 1); @(negedge clk); check("R2 gate drops with ocp", gate, 1'b0);
        step(1, 0); @(negedge clk); check("R2 gate stays blanked", gate, 1'b0);
        step(0, 0);
        step(1, 0); @(negedge clk); check("R2 next stroke drives", gate, 1'b1);
        step(0, 0);

        // R4 start-up timeout
        do_reset();
        ocp_until(370);
        @(negedge clk); check("R4 no prot before start-up limit", prot, 1'b0);
        ocp_until(400);
        @(negedge clk); check("R4 prot at start-up limit", prot, 1'b1);
        step(1, 0); step(1, 0);
        @(negedge clk); check("R6 gate held low in prot", gate, 1'b0);
        stroke(-1);
        @(negedge clk); check("R6 prot latched", prot, 1'b1);

        // R3 interruption clears the timer
        do_reset();
        ocp_until(300);
        stroke(-1);
        ocp_until(600);
        @(negedge clk); check("R3 clean cycle restarted timer", prot, 1'b0);
        ocp_until(700);
        @(negedge clk); check("R3 restarted timer expires", prot, 1'b1);

        // R5 regulated limit
        do_reset();
        @(posedge clk); #1; reg_ok = 1;
        @(posedge clk); #1; reg_ok = 0;
        ocp_until(1000);
        @(negedge clk); check("R5 no prot past start-up limit", prot, 1'b0);
        ocp_until(1900);
        @(negedge clk); check("R5 no prot just before regulated limit", prot, 1'b0);
        ocp_until(1950);
        @(negedge clk); check("R5 prot at regulated limit", prot, 1'b1);

        // R5 start-up limit again after reset
        do_reset();
        ocp_until(400);
        @(negedge clk); check("R5 reset restores start-up limit", prot, 1'b1);

        // R8 uvlo alone
        do_reset();
        @(posedge clk); #1; uvlo = 1;
        stroke(-1);
        step(1, 0); @(negedge clk); check("R8 gate with uvlo only", gate, 1'b1);
        step(0, 0); stroke(-1);
        @(negedge clk); check("R8 no prot on uvlo only", prot, 1'b0);

        // R7 uvlo with overpower event in same cycle
        step(1, 0); step(1, 1);
        step(1, 0);
        @(negedge clk); check("R7 prot on uvlo plus event", prot, 1'b1);
        step(0, 0);

        // R7 uvlo while timer running between strokes
        do_reset();
        ocp_until(20);
        step(0, 0); step(0, 0);
        @(negedge clk); check("R7 no prot before uvlo", prot, 1'b0);
        @(posedge clk); #1; uvlo = 1;
        @(posedge clk); #1; uvlo = 0;
        @(negedge clk); check("R7 prot on uvlo with running timer", prot, 1'b1);

        stroke(-1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule